// File: doc/BRIEF.md
# Parallel converter capture front end

This block runs an 8-bit two-step converter from the fabric. It makes the converter sample clock by dividing the system clock, and it drives the converter's active-low bus enable. Each data word is registered at a fixed point after the converter clock edge that makes it valid. The block then sends the words downstream as a valid/data stream. Each word carries the index of the converter falling edge that took its sample. Downstream logic can use that index to line the stream up with other sample-indexed data.

The converter takes a sample on each falling edge of its clock. The word for that sample is driven two and a half converter periods later, after a rising edge, and it settles 18 to 30 ns after that edge. The block counts these edges from the moment it starts the clock. It throws away the words that the pipeline still holds from before the start, so the first word it marks valid is sample 0. A parameter can complement every code so that the numeric value runs the other way against input voltage.

Top module: `adc_stream_capture`

## Requirements
- R1: While rst_ni is low, adc_clk_o is 0, adc_oe_no is 1 and valid_o is 0 at once, without waiting for a clock edge, and the fill and tag counters are cleared.
- R2: Each high phase of adc_clk_o lasts exactly HALF_DIV system cycles, and each low phase lasts at least HALF_DIV system cycles. Elaboration fails if HALF_DIV system periods come to less than 25 ns.
- R3: When en_i is sampled high on an idle block, the next system edge raises adc_clk_o and drops adc_oe_no together. When en_i is dropped during a high phase, that phase still completes, and at its falling edge adc_clk_o stays low and adc_oe_no returns to 1. adc_oe_no is never 1 while adc_clk_o is 1.
- R4: The bus is registered CAP_DLY system cycles after each rising edge of adc_clk_o. Elaboration fails unless this point lies more than 30 ns after the edge and less than 18 ns after the next rising edge.
- R5: After each start, the words from the first three rising edges are pipeline fill and give no valid_o. The first valid_o is high in the cycle after the 29th system rising edge, counting the starting edge as the first (defaults HALF_DIV=4, CAP_DLY=4).
- R6: tag_o of the first valid word after a start is 0, and each following valid word carries the previous tag plus 1. The tag equals the index of the converter falling edge that took the sample, counted from 0 at start.
- R7: valid_o is a one-cycle pulse, and data_o holds the bus word with bit 0 as the LSB.
- R8: With INVERT_CODE=1, data_o is the bitwise complement of the bus word (255 minus the code).
- R9: While en_i is low and the block is idle, the bus is ignored. adc_clk_o stays 0, adc_oe_no stays 1 and no valid_o is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run request for the converter clock and bus |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| adc_clk_o | output | 1 | Converter sample clock |
| adc_oe_no | output | 1 | Converter bus enable, active low |
| valid_o | output | 1 | Captured word valid, one-cycle pulse |
| data_o | output | DATA_W | Captured word, optionally complemented |
| tag_o | output | TAG_W | Falling-edge index of the sample |

## Verification
The converter clock edge follows the system edge at which en_i is sampled high. Each word is registered CAP_DLY cycles after its rising edge, and valid_o rises in the cycle after that, so the first valid appears 28 cycles after the start edge. The bench samples one nanosecond after a system edge when it counts that latency, and it samples on falling system edges for stream checks. The model drives every word 2.5 converter clocks late, using each of the delays 18, 21, 24 and 30 ns. The words can therefore be checked only if the capture point sits where R4 puts it. Stop and reset are checked a fixed number of edges after the stimulus: four cycles after en_i drops during a high phase, and at once for the asynchronous reset.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned MIN_HALF_PS = 25000;  // converter min high/low time
  localparam int unsigned DOUT_MIN_PS = 18000;  // earliest bus change after rise
  localparam int unsigned DOUT_MAX_PS = 30000;  // latest bus settle after rise
  localparam int unsigned FILL_WORDS  = 3;      // words preceding sample 0

  typedef enum logic [1:0] {
    CFG_OK        = 2'd0,
    CFG_HALF_LOW  = 2'd1,
    CFG_CAP_EARLY = 2'd2,
    CFG_CAP_LATE  = 2'd3
  } cfg_err_e;

  function automatic cfg_err_e check_cfg(int unsigned sys_ps, int unsigned half_div,
                                         int unsigned cap_dly);
    if (half_div * sys_ps < MIN_HALF_PS)                       return CFG_HALF_LOW;
    if (cap_dly < 2 || cap_dly * sys_ps <= DOUT_MAX_PS)         return CFG_CAP_EARLY;
    if (cap_dly >= 2 * half_div ||
        cap_dly * sys_ps >= 2 * half_div * sys_ps + DOUT_MIN_PS) return CFG_CAP_LATE;
    return CFG_OK;
  endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic run_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
  localparam int unsigned LEN_W = $clog2(2 * HALF_DIV + 2) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic sclk_q, run_q, rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= LAST;  // idle: low time already met
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (!run_q) begin
        if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        else if (en_i) begin
          run_q  <= 1'b1;
          sclk_q <= 1'b1;
          cnt_q  <= '0;
          rise_q <= 1'b1;
        end
      end else if (cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (sclk_q) begin
          sclk_q <= 1'b0;
          if (!en_i) run_q <= 1'b0;  // high phase always completes
        end else if (en_i) begin
          sclk_q <= 1'b1;
          rise_q <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign run_o  = run_q;
  assign rise_o = rise_q;

  // phase length checker
  logic             prev_q;
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      len_q  <= '1;
    end else begin
      prev_q <= sclk_q;
      if (sclk_q != prev_q) len_q <= LEN_W'(1);
      else if (len_q != '1) len_q <= len_q + 1'b1;
    end
  end

  a_r2_min_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q && !sclk_q) |-> (len_q == LEN_W'(HALF_DIV)));
  a_r2_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_q && sclk_q) |-> (len_q >= LEN_W'(HALF_DIV)));
endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TAG_W       = 16,
  parameter int unsigned CAP_DLY     = 4,
  parameter bit          INVERT_CODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rise_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned CD_W   = $clog2(CAP_DLY + 1);
  localparam int unsigned FILL_W = $clog2(FILL_WORDS + 1);
  localparam logic [CD_W-1:0]   CD_LOAD  = CD_W'(CAP_DLY - 1);
  localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(FILL_WORDS);

  logic [CD_W-1:0]   cd_q;
  logic [FILL_W-1:0] fill_q;
  logic [TAG_W-1:0]  nxt_q;
  logic [DATA_W-1:0] word;

  generate
    if (INVERT_CODE) begin : g_inv
      assign word = ~data_i;
    end else begin : g_pass
      assign word = data_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_q    <= '0;
      fill_q  <= '0;
      nxt_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      tag_o   <= '0;
    end else if (!run_i) begin
      cd_q    <= '0;
      fill_q  <= '0;
      nxt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) cd_q <= CD_LOAD;
      else if (cd_q != '0) cd_q <= cd_q - 1'b1;
      if (cd_q == CD_W'(1)) begin
        if (fill_q != FILL_TOP) begin
          fill_q <= fill_q + 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= word;
          tag_o   <= nxt_q;
          nxt_q   <= nxt_q + 1'b1;
        end
      end
    end
  end

  // stream checker
  logic             seen_q;
  logic [TAG_W-1:0] last_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (!run_i && !valid_o) begin
      seen_q <= 1'b0;
    end else if (valid_o) begin
      seen_q <= 1'b1;
      last_q <= tag_o;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_tag_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (tag_o == last_q + 1'b1));
  a_r6_first_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !seen_q) |-> (tag_o == '0));
endmodule

// File: rtl/adc_stream_capture.sv
module adc_stream_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned SYS_CLK_PS  = 8000,
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned CAP_DLY     = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TAG_W       = 16,
  parameter bit          INVERT_CODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_clk_o,
  output logic              adc_oe_no,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam cfg_err_e CFG = check_cfg(SYS_CLK_PS, HALF_DIV, CAP_DLY);

  generate
    if (CFG == CFG_HALF_LOW) begin : g_bad_half
      $fatal(1, "converter half period below 25 ns");
    end else if (CFG == CFG_CAP_EARLY) begin : g_bad_early
      $fatal(1, "capture point not past bus settle time");
    end else if (CFG == CFG_CAP_LATE) begin : g_bad_late
      $fatal(1, "capture point past next bus change");
    end
  endgenerate

  logic run, rise;

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) i_sclk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sclk_o (adc_clk_o),
    .run_o  (run),
    .rise_o (rise)
  );

  assign adc_oe_no = ~run;

  adc_word_capture #(
    .DATA_W      (DATA_W),
    .TAG_W       (TAG_W),
    .CAP_DLY     (CAP_DLY),
    .INVERT_CODE (INVERT_CODE)
  ) i_word_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .rise_i  (rise),
    .data_i  (adc_data_i),
    .valid_o (valid_o),
    .data_o  (data_o),
    .tag_o   (tag_o)
  );

  a_r3_oe_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_oe_no |-> !adc_clk_o);
  a_r9_no_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_oe_no && $past(adc_oe_no)) |-> !valid_o);
endmodule

// File: tb/test_adc_stream_capture.sv
`timescale 1ns/1ps
module test_adc_stream_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  wire  [7:0] bus;
  logic [7:0] model_q = 8'h00;
  logic sclk, oe_n, valid, sclk2, oe_n2, valid2;
  logic [7:0] dout, dout2;
  logic [15:0] tag, tag2;

  int tests = 0, fails = 0;
  int dly_ns = 18, base = 0, rise_n = 0, model_j = 0;
  int exp_tag = 0, n_valid = 0;
  bit prev_valid = 1'b0;
  realtime t_edge = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;

  always #4 clk = ~clk;

  adc_stream_capture i_adc_stream_capture (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .adc_data_i(bus),
    .adc_clk_o(sclk), .adc_oe_no(oe_n), .valid_o(valid), .data_o(dout), .tag_o(tag));

  adc_stream_capture #(.INVERT_CODE(1'b1)) i_adc_stream_capture_inv (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .adc_data_i(bus),
    .adc_clk_o(sclk2), .adc_oe_no(oe_n2), .valid_o(valid2), .data_o(dout2), .tag_o(tag2));

  // stimulus: (bus delay ns, code base, words to collect)
  localparam int NVEC = 4;
  localparam int VEC [NVEC][3] = '{'{18, 0, 6}, '{30, 226, 9}, '{24, 100, 5}, '{21, 37, 7}};

  function automatic logic [7:0] code_of(int k);
    return 8'((k * 29 + base) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // converter bus model: word for sample k after rise k+3
  assign bus = oe_n ? 8'hzz : model_q;
  always @(posedge sclk) begin
    model_j = rise_n;
    rise_n++;
    #(dly_ns);
    model_q = (model_j >= 3) ? code_of(model_j - 3) : 8'hA5;
  end
  always @(posedge oe_n) rise_n = 0;

  // clock phase monitor (R2)
  always @(sclk) begin
    if (rst_n && t_edge > 0.0) begin
      if (!sclk && ($realtime - t_edge) < min_hi) min_hi = $realtime - t_edge;
      if (sclk && ($realtime - t_edge) < min_lo) min_lo = $realtime - t_edge;
    end
    t_edge = $realtime;
  end

  // stream checker
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        chk(tag == 16'(exp_tag), "R6 tag", int'(tag), exp_tag);
        chk(dout == code_of(exp_tag), "R4 R7 data", int'(dout), int'(code_of(exp_tag)));
        chk(dout2 == ~code_of(exp_tag), "R8 inverted", int'(dout2), int'(~code_of(exp_tag)));
        exp_tag++;
        n_valid++;
      end
      if (valid && prev_valid) chk(1'b0, "R7 pulse", 2, 1);
      prev_valid = valid;
    end
  end

  task automatic go_idle();
    @(negedge clk) en = 1'b0;
    while (!oe_n) @(negedge clk);
    repeat (2 * 4 + 2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog R5 act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k, nv;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(oe_n == 1'b1, "R1 oe", int'(oe_n), 1);
    chk(sclk == 1'b0, "R1 clk", int'(sclk), 0);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 idle: bus ignored
    chk(sclk == 1'b0 && oe_n == 1'b1 && n_valid == 0, "R9 idle", n_valid, 0);

    // R3 / R5 start and fill latency
    base = 0; dly_ns = 30; exp_tag = 0;
    en = 1'b1;
    @(posedge clk); #1;
    k = 1;
    chk(sclk == 1'b1 && oe_n == 1'b0, "R3 start", int'({sclk, oe_n}), 2);
    while (!valid && k < 100) begin
      @(posedge clk); #1;
      k++;
    end
    chk(k == 29, "R5 first valid edge", k, 29);
    chk(tag == 16'd0, "R6 first tag", int'(tag), 0);
    go_idle();

    // table of runs
    for (int v = 0; v < NVEC; v++) begin
      dly_ns = VEC[v][0];
      base = VEC[v][1];
      exp_tag = 0;
      nv = n_valid;
      @(negedge clk) en = 1'b1;
      while (n_valid - nv < VEC[v][2]) @(negedge clk);
      go_idle();
      chk(n_valid - nv >= VEC[v][2], "R6 words", n_valid - nv, VEC[v][2]);
    end

    // R9 long idle with en low
    nv = n_valid;
    repeat (100) @(negedge clk);
    chk(n_valid == nv && oe_n && !sclk, "R9 no activity", n_valid - nv, 0);

    // R3 stop during high phase
    base = 5; exp_tag = 0;
    @(negedge clk) en = 1'b1;
    repeat (40) @(negedge clk);
    @(posedge sclk);
    @(negedge clk) en = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(sclk == 1'b1, "R3 high completes", int'(sclk), 1);
    @(posedge clk); #1;
    chk(oe_n == 1'b1 && sclk == 1'b0, "R3 stop", int'({oe_n, sclk}), 2);
    repeat (12) @(negedge clk);

    // R1 asynchronous reset mid-run, then clean restart
    base = 77; exp_tag = 0;
    @(negedge clk) en = 1'b1;
    while (n_valid == nv) @(negedge clk);
    repeat (5) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk(sclk == 1'b0 && oe_n == 1'b1 && valid == 1'b0, "R1 async reset",
           int'({sclk, oe_n, valid}), 2);
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_tag = 0;
    nv = n_valid;
    @(negedge clk) en = 1'b1;
    while (n_valid - nv < 4) @(negedge clk);
    go_idle();

    // R2 phase widths
    chk(min_hi == 32.0, "R2 high time", int'(min_hi), 32);
    chk(min_lo >= 32.0, "R2 low time", int'(min_lo), 32);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule